// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is the slave side of a byte-wide serial EEPROM on an SPI bus in mode 0,0. It sits between the SPI pins and a synchronous on-chip memory array of 2^ADDR_W bytes, 32768 by default. The array is split into 64-byte pages. The SPI pins are oversampled by the system clock `clk` and must already be synchronous to it. One SCK phase must last at least three `clk` cycles.

A host first sends a write-enable frame. It then sends a write frame made of an opcode, a 16-bit address and the data bytes. The data bytes collect in a page buffer, together with a per-byte valid mask. When CS rises to end the frame, a self-timed write cycle begins. During that cycle the buffered bytes move to the array one per clock, and protected addresses are skipped. The cycle lasts WR_CYCLES clocks. A read frame returns bytes on falling SCK edges. The address advances by one after each byte and wraps across the whole array. A hold input pauses a transfer in mid-frame. A protection selector fences off none, the upper quarter, the upper half or all of the array.

Top module: `ee_spi_slave`

## Requirements
- R1: After reset, so_oe is low, mem_we is low and the write enable latch is clear.
- R2: Read frame: opcode 0x03, then a 16-bit address sent MSB first. Address bits at and above ADDR_W are ignored. Data leaves on SO MSB first, one bit per falling SCK edge. The address then increments across the whole array and wraps from the last byte to byte 0.
- R3: The write enable opcode (0x06) sets the latch only when all 8 opcode bits have arrived and CS then rises. A shorter frame leaves the latch as it was. A write sent in the same CS frame as the write enable changes nothing.
- R4: A write frame (opcode 0x02) is discarded while the latch is clear. The write disable opcode (0x04), followed by CS rising, clears the latch.
- R5: When CS rises, a write commits only its complete data bytes. Trailing partial bits are dropped, and bytes of the page that were not sent keep their old values.
- R6: The write address wraps within its 64-byte page, from offset 63 back to offset 0. If more than 64 bytes are sent, the later bytes overwrite the earlier ones.
- R7: The array is written only during the internal cycle that starts when CS rises. That cycle lasts WR_CYCLES clocks and clears the latch when it ends.
- R8: Frames that begin while the internal cycle runs are ignored, whatever their opcode.
- R9: prot_sel selects the protected range. 0 protects nothing. 1 protects addresses whose two top bits are 11. 2 protects addresses whose top bit is 1. 3 protects the whole array. Bytes aimed at protected addresses are not written.
- R10: If wp_n is low when CS rises at the end of a write frame, the write is discarded.
- R11: While hold_n and cs_n are both low, SCK and SI are ignored and so_oe is low. When hold_n goes high again, the transfer resumes at the same bit.
- R12: Any other opcode makes the rest of the frame be ignored until CS goes high. Such a frame leaves the latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | SPI serial clock |
| si | input | 1 | SPI serial data in |
| cs_n | input | 1 | Active-low chip select |
| hold_n | input | 1 | Active-low transfer pause |
| wp_n | input | 1 | Active-low write protect |
| prot_sel | input | 2 | Protected range select |
| so | output | 1 | SPI serial data out |
| so_oe | output | 1 | Output enable for so (low means high impedance) |
| mem_addr | output | ADDR_W | Array address |
| mem_we | output | 1 | Array write strobe |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data, valid one clock after mem_addr |

## Verification
The bench uses a 1 KiB array and checks every result against a model of the array that it keeps itself. It tests a write enable frame cut off after 7 bits and a write sent in the same frame as the write enable. A design that set the latch too early would write the array in both cases. It sends writes that run past offset 63 or carry more than 64 bytes, and a write that ends with 3 stray bits. A design that got the page wrap or the byte mask wrong would spill into the next page or store the partial byte. It sends frames while the internal cycle runs, and frames with an unknown opcode. It toggles hold in the middle of reads and writes. It sweeps all four protection settings over one address in each quarter of the array. Each of these faults shows up as a wrong byte on read-back, or as so_oe going high.

// File: rtl/ee_spi_pkg.sv
package ee_spi_pkg;

  typedef enum logic [1:0] {PH_OP, PH_ADR, PH_DAT, PH_SKIP} phase_e;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;

  // top2 holds the two most significant address bits
  function automatic logic in_protected(input logic [1:0] sel, input logic [1:0] top2);
    case (sel)
      2'd0:    return 1'b0;
      2'd1:    return top2 == 2'b11;
      2'd2:    return top2[1];
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/ee_bus_frontend.sv
module ee_bus_frontend
  import ee_spi_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              si,
  input  logic              cs_n,
  input  logic              hold_n,
  input  logic              busy,
  input  logic [7:0]        mem_rdata,
  output logic              cs_rise,
  output logic              frame_ok,
  output logic              pend_wren,
  output logic              pend_wrdi,
  output logic              cmd_wr,
  output logic              got_byte,
  output logic              buf_clr,
  output logic              byte_ev,
  output logic [PAGE_W-1:0] byte_off,
  output logic [7:0]        byte_val,
  output logic [ADDR_W-1:0] addr_q,
  output logic              so,
  output logic              so_oe
);

  logic              sck_q, cs_q, cmd_rd, rd_on;
  phase_e            phase;
  logic [3:0]        bitcnt;
  logic [2:0]        rbit;
  logic [7:0]        rd_sh;
  logic [ADDR_W-2:0] shreg;

  wire              active  = !cs_n && hold_n && frame_ok;
  wire              rise    = active && sck && !sck_q;
  wire              fall    = active && !sck && sck_q;
  wire              cs_fall = !cs_n && cs_q;
  wire [ADDR_W-1:0] sh_next = {shreg, si};

  assign cs_rise = cs_n && !cs_q;
  assign so_oe   = rd_on && !cs_n && hold_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0; cs_q <= 1'b1; phase <= PH_OP; bitcnt <= '0; rbit <= '0;
      frame_ok <= 1'b0; pend_wren <= 1'b0; pend_wrdi <= 1'b0;
      cmd_wr <= 1'b0; cmd_rd <= 1'b0; got_byte <= 1'b0; rd_on <= 1'b0;
      buf_clr <= 1'b0; byte_ev <= 1'b0; byte_off <= '0; byte_val <= '0;
      addr_q <= '0; shreg <= '0; rd_sh <= '0; so <= 1'b0;
    end else begin
      sck_q   <= sck;
      cs_q    <= cs_n;
      byte_ev <= 1'b0;
      buf_clr <= 1'b0;
      if (cs_n) begin
        phase <= PH_OP; bitcnt <= '0; rd_on <= 1'b0;
      end
      if (cs_fall) begin
        frame_ok <= !busy; pend_wren <= 1'b0; pend_wrdi <= 1'b0;
        cmd_wr <= 1'b0; cmd_rd <= 1'b0; got_byte <= 1'b0;
      end
      if (rise) begin
        shreg <= sh_next[ADDR_W-2:0];
        case (phase)
          PH_OP: begin
            bitcnt <= bitcnt + 4'd1;
            if (bitcnt == 4'd7) begin
              bitcnt <= '0;
              phase  <= PH_SKIP;
              case (sh_next[7:0])
                OP_WREN:  pend_wren <= 1'b1;
                OP_WRDI:  pend_wrdi <= 1'b1;
                OP_WRITE: begin cmd_wr <= 1'b1; phase <= PH_ADR; end
                OP_READ:  begin cmd_rd <= 1'b1; phase <= PH_ADR; end
                default:  ;
              endcase
            end
          end
          PH_ADR: begin
            bitcnt <= bitcnt + 4'd1;
            if (bitcnt == 4'd15) begin
              bitcnt  <= '0;
              addr_q  <= sh_next;
              rbit    <= '0;
              phase   <= PH_DAT;
              buf_clr <= cmd_wr;
            end
          end
          PH_DAT: if (cmd_wr) begin
            bitcnt <= (bitcnt == 4'd7) ? 4'd0 : bitcnt + 4'd1;
            if (bitcnt == 4'd7) begin
              byte_ev  <= 1'b1;
              byte_val <= sh_next[7:0];
              byte_off <= addr_q[PAGE_W-1:0];
              got_byte <= 1'b1;
              addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (fall && phase == PH_DAT && cmd_rd) begin
        rd_on <= 1'b1;
        rbit  <= rbit + 3'd1;
        if (rbit == 3'd0) begin
          so     <= mem_rdata[7];
          rd_sh  <= {mem_rdata[6:0], 1'b0};
          addr_q <= addr_q + 1'b1;
        end else begin
          so    <= rd_sh[7];
          rd_sh <= {rd_sh[6:0], 1'b0};
        end
      end
    end
  end

  a_r11_hold_freezes_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && !cs_n) |=> ($stable(shreg) && $stable(so)));

  a_r2_so_only_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> (cmd_rd && phase == PH_DAT));

endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_off,
  input  logic [7:0]        wr_data,
  input  logic [PAGE_W-1:0] rd_off,
  output logic [7:0]        rd_data,
  output logic              rd_valid
);

  localparam int DEPTH = 1 << PAGE_W;

  logic [7:0]       slot [DEPTH];
  logic [DEPTH-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask <= '0;
    else if (clr)   mask <= '0;
    else if (wr_en) mask[wr_off] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) slot[wr_off] <= wr_data;
  end

  assign rd_data  = slot[rd_off];
  assign rd_valid = mask[rd_off];

endmodule

// File: rtl/ee_write_seq.sv
module ee_write_seq
  import ee_spi_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int PAGE_W    = 6,
  parameter int WR_CYCLES = 500000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [ADDR_W-PAGE_W-1:0] page_in,
  input  logic [1:0]               prot_sel,
  input  logic [7:0]               buf_data,
  input  logic                     buf_valid,
  output logic [PAGE_W-1:0]        buf_off,
  output logic                     busy,
  output logic                     done,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_waddr,
  output logic [7:0]               mem_wdata
);

  localparam int TW = $clog2(WR_CYCLES + 1);

  logic [TW-1:0]              tmr;
  logic [PAGE_W:0]            idx;
  logic [ADDR_W-PAGE_W-1:0]   page_q;
  logic [1:0]                 sel_q;

  assign buf_off   = idx[PAGE_W-1:0];
  assign mem_waddr = {page_q, idx[PAGE_W-1:0]};
  assign mem_wdata = buf_data;
  assign done      = busy && (tmr == TW'(WR_CYCLES - 1));
  assign mem_we    = busy && !idx[PAGE_W] && buf_valid &&
                     !in_protected(sel_q, mem_waddr[ADDR_W-1 -: 2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; tmr <= '0; idx <= '0; page_q <= '0; sel_q <= '0;
    end else if (start) begin
      busy <= 1'b1; tmr <= '0; idx <= '0; page_q <= page_in; sel_q <= prot_sel;
    end else if (busy) begin
      tmr <= tmr + 1'b1;
      if (!idx[PAGE_W]) idx <= idx + 1'b1;
      if (done) busy <= 1'b0;
    end
  end

  a_r7_timer_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tmr < TW'(WR_CYCLES)));

endmodule

// File: rtl/ee_spi_slave.sv
module ee_spi_slave
  import ee_spi_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int PAGE_W    = 6,
  parameter int WR_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              si,
  input  logic              cs_n,
  input  logic              hold_n,
  input  logic              wp_n,
  input  logic [1:0]        prot_sel,
  output logic              so,
  output logic              so_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);

  logic              cs_rise, frame_ok, pend_wren, pend_wrdi, cmd_wr, got_byte;
  logic              buf_clr, byte_ev, buf_valid, busy, done, wel, start;
  logic [PAGE_W-1:0] byte_off, buf_off;
  logic [7:0]        byte_val, buf_data;
  logic [ADDR_W-1:0] fe_addr, wr_addr;

  ee_bus_frontend #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_fe (
    .clk(clk), .rst_n(rst_n), .sck(sck), .si(si), .cs_n(cs_n), .hold_n(hold_n),
    .busy(busy), .mem_rdata(mem_rdata), .cs_rise(cs_rise), .frame_ok(frame_ok),
    .pend_wren(pend_wren), .pend_wrdi(pend_wrdi), .cmd_wr(cmd_wr),
    .got_byte(got_byte), .buf_clr(buf_clr), .byte_ev(byte_ev),
    .byte_off(byte_off), .byte_val(byte_val), .addr_q(fe_addr),
    .so(so), .so_oe(so_oe));

  ee_page_buf #(.PAGE_W(PAGE_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(byte_ev),
    .wr_off(byte_off), .wr_data(byte_val), .rd_off(buf_off),
    .rd_data(buf_data), .rd_valid(buf_valid));

  ee_write_seq #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .page_in(fe_addr[ADDR_W-1:PAGE_W]),
    .prot_sel(prot_sel), .buf_data(buf_data), .buf_valid(buf_valid),
    .buf_off(buf_off), .busy(busy), .done(done), .mem_we(mem_we),
    .mem_waddr(wr_addr), .mem_wdata(mem_wdata));

  assign start    = cs_rise && frame_ok && cmd_wr && got_byte && wel && wp_n && !busy;
  assign mem_addr = busy ? wr_addr : fe_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    wel <= 1'b0;
    else if (done)                 wel <= 1'b0;
    else if (cs_rise && frame_ok) begin
      if (pend_wren)               wel <= 1'b1;
      else if (pend_wrdi)          wel <= 1'b0;
    end
  end

  a_r7_we_only_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  a_r3_wel_sets_on_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(cs_rise));

  a_r7_cycle_starts_on_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise));

  a_r7_wel_clear_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);

endmodule

// File: tb/ee_spi_slave_tb_top.sv
module ee_spi_slave_tb_top;

  localparam int AW   = 10;
  localparam int SIZE = 1 << AW;
  localparam int WRC  = 300;
  localparam int WAIT = WRC + 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, si = 1'b0, cs_n = 1'b1, hold_n = 1'b1, wp_n = 1'b1;
  logic [1:0] prot_sel = 2'd0;
  logic so, so_oe, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  int n_chk = 0, n_bad = 0, we_cnt = 0;
  bit do_hold = 1'b0, finished = 1'b0;
  logic [7:0] mem [SIZE];
  logic [7:0] expv [SIZE];

  always #5 clk = ~clk;

  ee_spi_slave #(.ADDR_W(AW), .PAGE_W(6), .WR_CYCLES(WRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .si(si), .cs_n(cs_n), .hold_n(hold_n),
    .wp_n(wp_n), .prot_sel(prot_sel), .so(so), .so_oe(so_oe), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SIZE; i++) mem[i] <= 8'((i * 7 + 3) & 255);
    end else if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      we_cnt <= we_cnt + 1;
    end
    mem_rdata <= mem[mem_addr];
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  function automatic bit prot(input int sel, input int a);
    if (sel == 0) return 1'b0;
    if (sel == 1) return a >= (SIZE * 3) / 4;
    if (sel == 2) return a >= SIZE / 2;
    return 1'b1;
  endfunction

  function automatic logic [7:0] dat(input int d0, input int i);
    return 8'((d0 + i * 37) & 255);
  endfunction

  task automatic hold_glitch();
    hold_n = 1'b0;
    wclk(2);
    chk("R11 so_oe during hold", int'(so_oe), 0);
    for (int k = 0; k < 3; k++) begin
      sck = 1'b0; si = ~si; wclk(3);
      sck = 1'b1; wclk(3);
    end
    hold_n = 1'b1;
    wclk(3);
  endtask

  task automatic put_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sck = 1'b0; si = b[i]; wclk(4);
      sck = 1'b1; wclk(4);
      if (do_hold && i == 4) hold_glitch();
    end
  endtask

  task automatic get_byte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; wclk(4);
      b[i] = so;
      sck = 1'b1; wclk(4);
      if (do_hold && i == 4) hold_glitch();
    end
  endtask

  task automatic cs_lo();
    cs_n = 1'b0; wclk(4);
  endtask

  task automatic cs_hi();
    sck = 1'b0; wclk(4);
    cs_n = 1'b1; wclk(6);
  endtask

  task automatic op_frame(input logic [7:0] op, input int nbits);
    cs_lo(); put_bits(op, nbits); cs_hi();
  endtask

  task automatic wr(input int a, input int n, input int d0, input bit commit);
    cs_lo();
    put_bits(8'h02, 8); put_bits(8'(a >> 8), 8); put_bits(8'(a), 8);
    for (int i = 0; i < n; i++) put_bits(dat(d0, i), 8);
    cs_hi();
    if (commit) begin
      for (int i = 0; i < n; i++) begin
        int ad;
        ad = ((a & (SIZE - 1)) & ~63) | (((a & 63) + i) & 63);
        if (!prot(int'(prot_sel), ad)) expv[ad] = dat(d0, i);
      end
    end
    wclk(WAIT);
  endtask

  task automatic rd_chk(input int a, input int n, input string req);
    logic [7:0] b;
    cs_lo();
    put_bits(8'h03, 8); put_bits(8'(a >> 8), 8); put_bits(8'(a), 8);
    for (int i = 0; i < n; i++) begin
      get_byte(b);
      chk(req, int'(b), int'(expv[(a + i) & (SIZE - 1)]));
    end
    cs_hi();
  endtask

  initial begin
    for (int i = 0; i < SIZE; i++) expv[i] = 8'((i * 7 + 3) & 255);
    wclk(5);
    chk("R1 so_oe after reset", int'(so_oe), 0);
    chk("R1 mem_we after reset", int'(mem_we), 0);
    rst_n = 1'b1;
    wclk(5);

    // R2: wrap at array end with ignored high address bits, and a plain run
    rd_chk(16'hFFFE, 4, "R2 read wrap");
    rd_chk(16'h0010, 8, "R2 sequential read");

    // R1/R4: no latch after reset, write discarded
    wr(16'h0020, 2, 8'h11, 1'b0);
    rd_chk(16'h0020, 2, "R4 write without latch");

    // R3: 7-bit write-enable does not set the latch
    op_frame(8'h06, 7);
    wr(16'h0020, 2, 8'h22, 1'b0);
    rd_chk(16'h0020, 2, "R3 partial wren");

    // R3: write in the wren frame is dropped, latch set at CS rise
    cs_lo();
    put_bits(8'h06, 8); put_bits(8'h02, 8); put_bits(8'h00, 8); put_bits(8'h20, 8);
    put_bits(8'h99, 8);
    cs_hi();
    wclk(WAIT);
    rd_chk(16'h0020, 1, "R3 write in wren frame");
    begin
      int base;
      base = we_cnt;
      wr(16'h0020, 3, 8'h33, 1'b1);
      chk("R7 strobes in one cycle", we_cnt - base, 3);
    end
    rd_chk(16'h001F, 5, "R5 committed bytes");

    // R7: latch cleared at end of cycle
    wr(16'h0030, 1, 8'h44, 1'b0);
    rd_chk(16'h0030, 1, "R7 latch cleared");

    // R4: write disable
    op_frame(8'h06, 8); op_frame(8'h04, 8);
    wr(16'h0030, 1, 8'h55, 1'b0);
    rd_chk(16'h0030, 1, "R4 wrdi");

    // R6: page wrap and overrun
    op_frame(8'h06, 8);
    wr(16'h013E, 5, 8'h66, 1'b1);
    rd_chk(16'h013C, 4, "R6 page end");
    rd_chk(16'h0100, 4, "R6 page start");
    rd_chk(16'h0140, 1, "R6 next page untouched");
    op_frame(8'h06, 8);
    wr(16'h0080, 66, 8'h07, 1'b1);
    rd_chk(16'h0080, 64, "R6 overrun");

    // R5: trailing partial byte dropped
    op_frame(8'h06, 8);
    cs_lo();
    put_bits(8'h02, 8); put_bits(8'h00, 8); put_bits(8'h40, 8);
    put_bits(dat(8'h5A, 0), 8); put_bits(dat(8'h5A, 1), 8); put_bits(8'hFF, 3);
    cs_hi();
    expv[16'h040] = dat(8'h5A, 0);
    expv[16'h041] = dat(8'h5A, 1);
    wclk(WAIT);
    rd_chk(16'h0040, 3, "R5 partial byte");

    // R10: write protect pin
    op_frame(8'h06, 8);
    wp_n = 1'b0;
    wr(16'h0050, 2, 8'h77, 1'b0);
    wp_n = 1'b1;
    rd_chk(16'h0050, 2, "R10 wp_n low");

    // R12: unknown opcode ignored, latch kept
    op_frame(8'h06, 8);
    cs_lo();
    put_bits(8'h05, 8); put_bits(8'h02, 8); put_bits(8'h00, 8); put_bits(8'h60, 8);
    put_bits(8'hAB, 8);
    cs_hi();
    wclk(WAIT);
    rd_chk(16'h0060, 1, "R12 unknown opcode");
    wr(16'h0060, 1, 8'h3C, 1'b1);
    rd_chk(16'h0060, 1, "R12 latch kept");

    // R8: frames during cycle ignored
    op_frame(8'h06, 8);
    cs_lo();
    put_bits(8'h02, 8); put_bits(8'h00, 8); put_bits(8'h70, 8); put_bits(dat(8'h48, 0), 8);
    cs_hi();
    expv[16'h070] = dat(8'h48, 0);
    op_frame(8'h06, 8);
    begin
      logic [7:0] b;
      int oe_seen;
      oe_seen = 0;
      cs_lo();
      put_bits(8'h03, 8); put_bits(8'h00, 8); put_bits(8'h70, 8);
      for (int i = 7; i >= 0; i--) begin
        sck = 1'b0; wclk(4);
        b[i] = so;
        oe_seen = oe_seen | int'(so_oe);
        sck = 1'b1; wclk(4);
      end
      cs_hi();
      chk("R8 read during cycle", oe_seen, 0);
    end
    wclk(WAIT);
    rd_chk(16'h0070, 1, "R8 cycle result");
    wr(16'h0071, 1, 8'h21, 1'b0);
    rd_chk(16'h0071, 1, "R8 wren during cycle ignored");

    // R11: hold in the middle of a write and a read
    op_frame(8'h06, 8);
    do_hold = 1'b1;
    wr(16'h00A0, 4, 8'h90, 1'b1);
    rd_chk(16'h00A0, 4, "R11 held transfer");
    do_hold = 1'b0;

    // R9: protection sweep, one address per quarter
    for (int sel = 0; sel < 4; sel++) begin
      prot_sel = 2'(sel);
      for (int q = 0; q < 4; q++) begin
        int a;
        a = q * (SIZE / 4) + 16 + sel;
        op_frame(8'h06, 8);
        wr(a, 1, 8'h80 + sel * 16 + q, 1'b1);
        rd_chk(a, 1, "R9 protection");
      end
    end
    prot_sel = 2'd0;

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule